// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block sends bytes as the only master on a two-wire I2C bus. A host reaches it through four byte-wide registers. It selects transmit-master operation in a mode register and requests a start through a bus command register. It then feeds bytes into a one-deep holding buffer that sits in front of the shift register, so the next byte can be queued while the current one is still going out. Four status flags report progress: buffer empty, transfer end, the acknowledge level the slave returned, and a stop seen on the wires. The host clears the flags by writing ones to them.

The block drives SCL and SDA as open-drain outputs that only ever pull low, and it reads both wires back. Every SCL high phase and every SCL low phase lasts HALF_CYC clock cycles. SCL is held low for as long as the buffer stays empty. A monitor on the sampled wires recognises start and stop conditions. From them it keeps a bus-busy indication and the stop flag.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset the mode register (address 0) reads 0x00, the bus command register (address 1) reads 0x00, and the status register (address 2) reads 0x80, which is buffer-empty alone. Both wires are released.
- R2: Mode bits are bit 7 (master) and bit 6 (transmit) of address 0. When both are 1 and the bus is idle, a write of 0x80 to address 1 makes SDA fall while SCL is high. After that, address 1 bit 7 reads 1 (bus busy) and status bit 7 (buffer empty) reads 1.
- R3: A start request is ignored if bit 6 of the address 1 write is 1, or if the master and transmit bits are not both set. In that case no start appears on the wires.
- R4: Each byte written to address 3 goes out MSB first, followed by a ninth acknowledge clock. Every SCL high phase inside a byte lasts exactly HALF_CYC cycles, and every low phase lasts at least HALF_CYC cycles. SDA does not change while SCL is high in the middle of a byte.
- R5: Writing address 3 clears status bit 7. Bit 7 sets again when the byte moves into the shift register. A byte written while another is shifting follows it directly, and status bit 6 does not set in between.
- R6: Status bit 6 (transfer end) sets when an acknowledge clock completes and the buffer is empty. SCL then stays low until data or a stop arrives. A write to address 3 clears bit 6.
- R7: Status bit 5 holds the SDA level sampled in the ninth clock of the latest byte: 0 means acknowledged, 1 means not acknowledged.
- R8: A write of 0x00 to address 1 during a transfer makes SDA rise while SCL is high once the buffer is empty. Status bit 4 then sets and address 1 bit 7 returns to 0.
- R9: Writing 1 to status bit 7, bit 6 or bit 4 clears that flag. Writing 0 to a flag leaves it unchanged, and bit 5 ignores writes.
- R10: If the write to address 3 lands in the same cycle in which the acknowledge clock ends with the buffer empty, bit 6 stays 0 and that byte is sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 bus command, 2 status, 3 transmit data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |

## Verification
The end of an acknowledge clock and a host write to the transmit data register can fall in the same cycle. Depending on whether the buffer is empty or full at that moment, this becomes a race between setting transfer-end and accepting a new byte, or between moving a byte out of the buffer and refilling it. The bench provokes the first case exactly: it watches the ninth SCL rise on the wires, counts HALF_CYC-1 further cycles, and issues the write so that it lands on the closing edge of the high phase. It then checks that transfer-end reads 0 in the next cycle and that the late byte follows on the bus after a single extra low cycle.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // register map
    typedef enum logic [ADDR_W-1:0] {
        RA_MODE = 2'd0,
        RA_BUS  = 2'd1,
        RA_STAT = 2'd2,
        RA_TXD  = 2'd3
    } reg_addr_e;

    // bit positions
    localparam int MODE_MST  = 7;
    localparam int MODE_TX   = 6;
    localparam int BUS_BUSY  = 7;
    localparam int BUS_GUARD = 6;
    localparam int ST_EMPTY  = 7;
    localparam int ST_END    = 6;
    localparam int ST_NACK   = 5;
    localparam int ST_STOP   = 4;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_HOLD,
        SQ_WAIT,
        SQ_BIT_LO,
        SQ_BIT_HI,
        SQ_ACK_LO,
        SQ_ACK_HI,
        SQ_STOP_LO,
        SQ_STOP_HI,
        SQ_STOP_REL
    } seq_state_e;

    typedef struct packed {
        logic empty;
        logic done;
        logic nack;
        logic stop;
    } flags_t;

    typedef struct packed {
        logic load;
        logic start_go;
        logic end_set;
        logic ack_stb;
        logic ack_val;
    } seq_evt_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    // wire drive for each sequencer state; data bit is the shift MSB
    function automatic line_drv_t drive_for(seq_state_e st, logic bit_val);
        line_drv_t d;
        case (st)
            SQ_START:    d = '{scl_low: 1'b0, sda_low: 1'b1};
            SQ_HOLD:     d = '{scl_low: 1'b1, sda_low: 1'b1};
            SQ_WAIT:     d = '{scl_low: 1'b1, sda_low: 1'b1};
            SQ_BIT_LO:   d = '{scl_low: 1'b1, sda_low: !bit_val};
            SQ_BIT_HI:   d = '{scl_low: 1'b0, sda_low: !bit_val};
            SQ_ACK_LO:   d = '{scl_low: 1'b1, sda_low: 1'b0};
            SQ_ACK_HI:   d = '{scl_low: 1'b0, sda_low: 1'b0};
            SQ_STOP_LO:  d = '{scl_low: 1'b1, sda_low: 1'b1};
            SQ_STOP_HI:  d = '{scl_low: 1'b0, sda_low: 1'b1};
            default:     d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_mtx_busmon.sv
module i2c_mtx_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_busy,
    output logic stop_seen
);
    logic s_scl, s_sda, p_scl, p_sda;
    logic start_det, stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_scl <= 1'b1;
            s_sda <= 1'b1;
            p_scl <= 1'b1;
            p_sda <= 1'b1;
        end else begin
            s_scl <= scl_in;
            s_sda <= sda_in;
            p_scl <= s_scl;
            p_sda <= s_sda;
        end
    end

    assign start_det = p_scl && s_scl && p_sda && !s_sda;
    assign stop_det  = p_scl && s_scl && !p_sda && s_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_busy <= 1'b0;
        end else if (start_det) begin
            bus_busy <= 1'b1;
        end else if (stop_det) begin
            bus_busy <= 1'b0;
        end
    end

    assign stop_seen = stop_det;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_det |=> bus_busy);   // R2
    AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !bus_busy);   // R8

endmodule

// File: rtl/i2c_mtx_seq.sv
module i2c_mtx_seq
    import i2c_mtx_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bus_busy,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              sda_in,
    output seq_evt_t          evt,
    output line_drv_t         drv
);
    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam int IDX_W = $clog2(DATA_W);

    seq_state_e         st, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  sh;
    logic [IDX_W-1:0]   bit_idx;
    logic               stop_pend;
    logic               phase_end;

    assign phase_end = (cnt == CNT_W'(HALF_CYC - 1));

    always_comb begin
        nxt = st;
        evt = '0;
        case (st)
            SQ_IDLE: begin
                if (start_req && enable && !bus_busy) begin
                    nxt          = SQ_START;
                    evt.start_go = 1'b1;
                end
            end
            SQ_START:  if (phase_end) nxt = SQ_HOLD;
            SQ_HOLD:   if (phase_end) nxt = SQ_WAIT;
            SQ_WAIT: begin
                if (buf_full) begin
                    evt.load = 1'b1;
                    nxt      = SQ_BIT_LO;
                end else if (stop_pend) begin
                    nxt = SQ_STOP_LO;
                end
            end
            SQ_BIT_LO: if (phase_end) nxt = SQ_BIT_HI;
            SQ_BIT_HI: begin
                if (phase_end) nxt = (bit_idx == '0) ? SQ_ACK_LO : SQ_BIT_LO;
            end
            SQ_ACK_LO: if (phase_end) nxt = SQ_ACK_HI;
            SQ_ACK_HI: begin
                if (phase_end) begin
                    evt.ack_stb = 1'b1;
                    evt.ack_val = sda_in;
                    if (buf_full) begin
                        evt.load = 1'b1;
                        nxt      = SQ_BIT_LO;
                    end else begin
                        evt.end_set = 1'b1;
                        nxt         = SQ_WAIT;
                    end
                end
            end
            SQ_STOP_LO:  if (phase_end) nxt = SQ_STOP_HI;
            SQ_STOP_HI:  if (phase_end) nxt = SQ_STOP_REL;
            SQ_STOP_REL: if (phase_end) nxt = SQ_IDLE;
            default:     nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            cnt       <= '0;
            sh        <= '0;
            bit_idx   <= '0;
            stop_pend <= 1'b0;
        end else begin
            st  <= nxt;
            cnt <= (nxt != st) ? '0 : cnt + 1'b1;
            if (evt.load) begin
                sh      <= buf_data;
                bit_idx <= IDX_W'(DATA_W - 1);
            end else if (st == SQ_BIT_HI && phase_end) begin
                sh      <= {sh[DATA_W-2:0], 1'b0};
                bit_idx <= bit_idx - 1'b1;
            end
            if (st == SQ_IDLE) begin
                stop_pend <= 1'b0;
            end else if (stop_req) begin
                stop_pend <= 1'b1;
            end else if (nxt == SQ_STOP_LO) begin
                stop_pend <= 1'b0;
            end
        end
    end

    assign drv = drive_for(st, sh[DATA_W-1]);

    AST_SDA_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_BIT_HI && $past(st) == SQ_BIT_HI) |-> $stable(drv.sda_low));   // R4

endmodule

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
    import i2c_mtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  seq_evt_t          evt,
    input  logic              stop_seen,
    input  logic              bus_busy,
    output logic [DATA_W-1:0] rdata,
    output logic              enable,
    output logic              start_req,
    output logic              stop_req,
    output logic              buf_full,
    output logic [DATA_W-1:0] buf_data
);
    logic   mst, tx;
    flags_t fl;
    logic   wr_mode, wr_bus, wr_stat, wr_txd;

    assign wr_mode = wr && (addr == RA_MODE);
    assign wr_bus  = wr && (addr == RA_BUS);
    assign wr_stat = wr && (addr == RA_STAT);
    assign wr_txd  = wr && (addr == RA_TXD);

    assign start_req = wr_bus && !wdata[BUS_GUARD] && wdata[BUS_BUSY];
    assign stop_req  = wr_bus && !wdata[BUS_GUARD] && !wdata[BUS_BUSY];
    assign enable    = mst && tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            mst      <= 1'b0;
            tx       <= 1'b0;
            buf_full <= 1'b0;
            buf_data <= '0;
            fl       <= '{empty: 1'b1, done: 1'b0, nack: 1'b0, stop: 1'b0};
        end else begin
            if (wr_mode) begin
                mst <= wdata[MODE_MST];
                tx  <= wdata[MODE_TX];
            end
            // a host write outranks the shift register taking the buffer
            if (wr_txd) begin
                buf_data <= wdata;
                buf_full <= 1'b1;
            end else if (evt.load) begin
                buf_full <= 1'b0;
            end
            if (wr_txd) begin
                fl.empty <= 1'b0;
            end else if (evt.load || (evt.start_go && !buf_full)) begin
                fl.empty <= 1'b1;
            end else if (wr_stat && wdata[ST_EMPTY]) begin
                fl.empty <= 1'b0;
            end
            if (wr_txd) begin
                fl.done <= 1'b0;
            end else if (evt.end_set) begin
                fl.done <= 1'b1;
            end else if (wr_stat && wdata[ST_END]) begin
                fl.done <= 1'b0;
            end
            if (evt.ack_stb) begin
                fl.nack <= evt.ack_val;
            end
            if (stop_seen) begin
                fl.stop <= 1'b1;
            end else if (wr_stat && wdata[ST_STOP]) begin
                fl.stop <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_MODE: begin
                rdata[MODE_MST] = mst;
                rdata[MODE_TX]  = tx;
            end
            RA_BUS:  rdata[BUS_BUSY] = bus_busy;
            RA_STAT: begin
                rdata[ST_EMPTY] = fl.empty;
                rdata[ST_END]   = fl.done;
                rdata[ST_NACK]  = fl.nack;
                rdata[ST_STOP]  = fl.stop;
            end
            default: rdata = buf_data;
        endcase
    end

    AST_EMPTY_VS_BUFFER: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !fl.empty);   // R5
    AST_END_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fl.done |-> !buf_full);   // R6
    AST_NACK_HELD: assert property (@(posedge clk) disable iff (rst)
        !evt.ack_stb |=> $stable(fl.nack));   // R7
    AST_WRITE_WINS_END: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> !fl.done);   // R10

endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
    import i2c_mtx_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    seq_evt_t          evt;
    line_drv_t         drv;
    logic              bus_busy, stop_seen;
    logic              enable, start_req, stop_req, buf_full;
    logic [DATA_W-1:0] buf_data;

    i2c_mtx_busmon u_mon (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .bus_busy  (bus_busy),
        .stop_seen (stop_seen)
    );

    i2c_mtx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .evt       (evt),
        .stop_seen (stop_seen),
        .bus_busy  (bus_busy),
        .rdata     (reg_rdata),
        .enable    (enable),
        .start_req (start_req),
        .stop_req  (stop_req),
        .buf_full  (buf_full),
        .buf_data  (buf_data)
    );

    i2c_mtx_seq #(.HALF_CYC(HALF_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .bus_busy  (bus_busy),
        .start_req (start_req),
        .stop_req  (stop_req),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .sda_in    (sda_in),
        .evt       (evt),
        .drv       (drv)
    );

    assign scl_drive_low = drv.scl_low;
    assign sda_drive_low = drv.sda_low;

endmodule

// File: tb/i2c_mtx_ctrl_tb.sv
module i2c_mtx_ctrl_tb;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_dl, sda_dl;
    logic       slave_pull = 1'b0;
    logic       scl_line, sda_line;

    always #5 clk = ~clk;

    assign scl_line = ~scl_dl;
    assign sda_line = ~(sda_dl | slave_pull);

    i2c_mtx_ctrl #(.HALF_CYC(HALF)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .scl_drive_low (scl_dl),
        .sda_drive_low (sda_dl)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural bus observer and acknowledging slave
    logic       m_scl = 1'b1, m_sda = 1'b1;
    int         bitpos = 0, nbits = 0, hi_len = 0, lo_len = 0;
    bit         in_frame = 0;
    bit         nack_next = 0;
    logic [7:0] part = 8'd0;
    logic [7:0] got_bytes[$];
    logic       got_acks[$];
    int         n_start = 0, n_stop = 0, ack_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (m_scl && scl_line && (sda_line != m_sda)) begin
                if (in_frame && bitpos >= 1 && bitpos <= 8)
                    check("R4 SDA moved under SCL high mid-byte", 1, 0);
                if (!sda_line) begin
                    n_start++;
                    in_frame = 1;
                    bitpos = -1;
                    nbits = 0;
                end else begin
                    n_stop++;
                    in_frame = 0;
                    nbits = 0;
                end
            end
            if (!m_scl && scl_line) begin
                if (in_frame && lo_len < HALF)
                    check("R4 SCL low phase too short", lo_len, HALF);
                hi_len = 1;
                if (in_frame) begin
                    if (bitpos >= 0 && bitpos < 8) begin
                        part = {part[6:0], sda_line};
                        nbits++;
                        if (nbits == 8) begin
                            got_bytes.push_back(part);
                            nbits = 0;
                        end
                    end else if (bitpos == 8) begin
                        got_acks.push_back(sda_line);
                        ack_cnt++;
                    end
                end
            end else if (m_scl && !scl_line) begin
                if (in_frame && bitpos >= 0)
                    check("R4 SCL high phase length", hi_len, HALF);
                lo_len = 1;
                if (in_frame) begin
                    bitpos++;
                    if (bitpos == 8) begin
                        slave_pull = !nack_next;
                    end else if (bitpos == 9) begin
                        slave_pull = 1'b0;
                        bitpos = 0;
                    end
                end
            end else if (scl_line) begin
                hi_len++;
            end else begin
                lo_len++;
            end
            m_scl = scl_line;
            m_sda = sda_line;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_stat(input logic [7:0] mask, output bit ok);
        logic [7:0] d;
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            rd(2'd2, d);
            if ((d & mask) != 0) begin
                ok = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit ok;
        int tgt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(2'd2, d); check("R1 status after reset", d, 8'h80);
        rd(2'd0, d); check("R1 mode after reset", d, 8'h00);
        rd(2'd1, d); check("R1 bus busy after reset", d, 8'h00);
        check("R1 SCL released", scl_line, 1);
        check("R1 SDA released", sda_line, 1);

        wr(2'd1, 8'h80);
        repeat (4 * HALF) @(negedge clk);
        check("R3 start ignored with mode off", n_start, 0);
        wr(2'd0, 8'hC0);
        rd(2'd0, d); check("R2 mode bits read back", d, 8'hC0);
        wr(2'd1, 8'hC0);
        repeat (4 * HALF) @(negedge clk);
        check("R3 start ignored with guard bit set", n_start, 0);
        check("R3 SDA still released", sda_line, 1);

        wr(2'd2, 8'h80);
        rd(2'd2, d); check("R9 empty flag cleared by write-one", d, 8'h00);

        wr(2'd1, 8'h80);
        repeat (HALF) @(negedge clk);
        check("R2 start condition on bus", n_start, 1);
        rd(2'd1, d); check("R2 bus busy after start", d, 8'h80);
        rd(2'd2, d); check("R2 empty flag set by start", d, 8'h80);

        wr(2'd3, 8'hA6);
        rd(2'd2, d); check("R5 empty flag cleared by data write", d, 8'h00);
        wait_stat(8'h80, ok); check("R5 empty set on move to shifter", ok, 1);
        check("R5 first byte still shifting", got_bytes.size(), 0);
        wr(2'd3, 8'h3C);
        rd(2'd2, d); check("R5 queued byte held", d & 8'h80, 0);
        wait_stat(8'h80, ok); check("R5 second byte taken", ok, 1);
        rd(2'd2, d); check("R5 no transfer end between bytes", d & 8'h40, 0);
        check("R4 first byte count", got_bytes.size(), 1);
        if (got_bytes.size() > 0) check("R4 first byte MSB first", got_bytes[0], 8'hA6);
        if (got_acks.size() > 0) check("R7 ack level on bus", got_acks[0], 0);

        wait_stat(8'h40, ok); check("R6 transfer end set", ok, 1);
        check("R4 second byte count", got_bytes.size(), 2);
        if (got_bytes.size() > 1) check("R4 second byte", got_bytes[1], 8'h3C);
        rd(2'd2, d); check("R6 R7 status after acked last byte", d, 8'hC0);
        repeat (3 * HALF) @(negedge clk);
        check("R6 SCL held low while empty", scl_line, 0);

        nack_next = 1;
        wr(2'd3, 8'h5A);
        rd(2'd2, d); check("R6 transfer end cleared by data write", d & 8'h40, 0);
        wait_stat(8'h40, ok); check("R6 transfer end after nacked byte", ok, 1);
        if (got_bytes.size() > 2) check("R4 third byte", got_bytes[2], 8'h5A);
        rd(2'd2, d); check("R7 nack captured", d, 8'hE0);

        wr(2'd2, 8'h20);
        rd(2'd2, d); check("R9 write to ack bit and zeros ignored", d, 8'hE0);
        wr(2'd2, 8'h40);
        rd(2'd2, d); check("R9 transfer end cleared alone", d, 8'hA0);

        nack_next = 0;
        tgt = ack_cnt + 1;
        wr(2'd3, 8'h81);
        wait (ack_cnt == tgt);
        repeat (HALF - 1) @(negedge clk);
        wr(2'd3, 8'h7E);
        rd(2'd2, d); check("R10 write at ack end keeps end flag low", d, 8'h00);
        wait_stat(8'h40, ok); check("R10 late byte finishes", ok, 1);
        check("R10 byte count after collision", got_bytes.size(), 5);
        if (got_bytes.size() > 4) begin
            check("R10 byte before collision", got_bytes[3], 8'h81);
            check("R10 colliding byte sent", got_bytes[4], 8'h7E);
        end

        wr(2'd1, 8'h00);
        wait_stat(8'h10, ok); check("R8 stop flag set", ok, 1);
        check("R8 stop condition on bus", n_stop, 1);
        repeat (2) @(negedge clk);
        rd(2'd1, d); check("R8 bus free after stop", d, 8'h00);
        wr(2'd2, 8'h10);
        rd(2'd2, d); check("R9 stop flag cleared", d & 8'h10, 0);
        wr(2'd0, 8'h00);
        rd(2'd0, d); check("R8 mode returned to slave receive", d, 8'h00);
        check("R8 SCL released at end", scl_line, 1);
        check("R8 SDA released at end", sda_line, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule